// File: doc/BRIEF.md
# Beam Position Latch Readout

This block freezes a snapshot of the video beam position and hands it to an 8-bit CPU one byte at a time. A free-running horizontal dot counter and a vertical line counter, each 9 bits wide, arrive as live inputs. A read of the trigger register copies both counters into holding registers. The copy happens only while bit 7 of an external I/O port is high. The trigger read itself returns the CPU's open-bus byte, because the trigger register has no data of its own.

Each held counter is read through its own register, and each register has its own low/high toggle. The first read returns bits 7..0. The second read returns bit 8 in bit 0, and the upper seven bits come from the last byte the block placed on the bus. A status register reports:

- the current field;
- the region;
- a 4-bit version number;
- a sticky flag that says a capture happened since the last status read.

Reading the status register also resets both toggles. A shared bus-latch byte models the open-bus bits that are merged into the counter high bytes and into the status byte.

Top module: `beam_latch_readout`

## Requirements
- R1: After reset the bus latch and `rdData` are 0xFF, both toggles are 0, both held counters are 0 and the capture flag is clear.
- R2: A read with `rdSel`=0 (trigger) while `ioGate` is 1 copies `hLive` and `vLive` into the held counters. The byte returned for that read is `cpuOpenBus`.
- R3: A trigger read while `ioGate` is 0 leaves the held counters unchanged.
- R4: A capture sets the flag. A status read (`rdSel`=3) with `ioGate` at 1 returns bit 6 equal to the flag and then clears the flag.
- R5: While `ioGate` is 0, status bit 6 reads as 1 and the flag is not cleared.
- R6: Reads with `rdSel`=1 (horizontal) and `rdSel`=2 (vertical) each use their own toggle. When the toggle is 0 the read returns counter bits 7..0. When the toggle is 1 it returns counter bit 8 in bit 0 and bus-latch bits 7..1 above it. The toggle inverts after every read of its counter.
- R7: A status read sets both toggles to 0.
- R8: The status byte is built as follows: bit 7 = `fieldIn`, bit 6 as in R4/R5, bit 5 = bus-latch bit 5, bit 4 = `region50` (1 for 50 Hz), bits 3..0 = parameter VERSION.
- R9: Counter reads and status reads load the returned byte into the bus latch. Trigger reads leave the bus latch unchanged.
- R10: The byte for a read strobed at a clock edge appears on `rdData` with `rdValid` high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | CPU read strobe, one cycle per read |
| rdSel | input | 2 | Register select: 0 trigger, 1 horizontal, 2 vertical, 3 status |
| ioGate | input | 1 | External I/O port bit 7, enables capture |
| hLive | input | 9 | Live horizontal dot counter |
| vLive | input | 9 | Live vertical line counter |
| fieldIn | input | 1 | Current field |
| region50 | input | 1 | 1 for 50 Hz region, 0 for 60 Hz |
| cpuOpenBus | input | 8 | CPU open-bus byte, returned on trigger reads |
| rdData | output | 8 | Read result byte |
| rdValid | output | 1 | High for the cycle that follows a read strobe |

## Verification
A toggle that is out of step shows up on the next counter read: a high byte comes back where a low byte was expected, with wrong upper bits. A stale capture flag shows up in bit 6 of the next status read with the gate high. A bus latch that was not updated damages bits 7..1 of the next counter high byte and bit 5 of the next status byte. Each of these faults reaches the port within one or two reads of the stimulus that caused it. The bench therefore interleaves the three read kinds closely and predicts every byte from its own model of the toggles, the flag and the bus latch.

// File: rtl/beam_latch_pkg.sv
package beam_latch_pkg;
  typedef enum logic [1:0] {
    SEL_TRIG = 2'd0,
    SEL_HORZ = 2'd1,
    SEL_VERT = 2'd2,
    SEL_STAT = 2'd3
  } regSelT;

  typedef struct packed {
    logic anyRead;
    logic readTrig;
    logic capture;
    logic readH;
    logic readV;
    logic readStat;
    logic hiByteH;
    logic hiByteV;
    logic statBit6;
  } strobeT;
endpackage

// File: rtl/beam_latch_ctrl.sv
module beam_latch_ctrl
  import beam_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStrobe,
  input  logic [1:0] rdSel,
  input  logic       ioGate,
  output strobeT     st
);
  logic hTog, vTog, flagQ;
  logic selTrig, selH, selV, selStat;

  assign selTrig = rdStrobe && (rdSel == SEL_TRIG);
  assign selH    = rdStrobe && (rdSel == SEL_HORZ);
  assign selV    = rdStrobe && (rdSel == SEL_VERT);
  assign selStat = rdStrobe && (rdSel == SEL_STAT);

  always_comb begin
    st          = '0;
    st.anyRead  = rdStrobe;
    st.readTrig = selTrig;
    st.capture  = selTrig && ioGate;
    st.readH    = selH;
    st.readV    = selV;
    st.readStat = selStat;
    st.hiByteH  = hTog;
    st.hiByteV  = vTog;
    st.statBit6 = !ioGate || flagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hTog  <= 1'b0;
      vTog  <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      if (selStat) begin
        hTog <= 1'b0;
        vTog <= 1'b0;
      end else begin
        if (selH) hTog <= !hTog;
        if (selV) vTog <= !vTog;
      end
      if (st.capture) flagQ <= 1'b1;
      else if (selStat && ioGate) flagQ <= 1'b0;
    end
  end

  a_r4_capture_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |=> flagQ);
  a_r4_status_clears_flag: assert property (@(posedge clk) disable iff (!rstN)
    (selStat && ioGate) |=> !flagQ);
  a_r5_flag_kept_ungated: assert property (@(posedge clk) disable iff (!rstN)
    (selStat && !ioGate && flagQ) |=> flagQ);
  a_r7_status_clears_toggles: assert property (@(posedge clk) disable iff (!rstN)
    selStat |=> (!hTog && !vTog));
  a_r6_h_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    selH |=> (hTog != $past(hTog)));
  a_r6_v_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    selV |=> (vTog != $past(vTog)));
endmodule

// File: rtl/beam_latch_dpath.sv
module beam_latch_dpath
  import beam_latch_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int DATA_W  = 8,
  parameter logic [3:0] VERSION = 4'd3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            st,
  input  logic [CNT_W-1:0]  hLive,
  input  logic [CNT_W-1:0]  vLive,
  input  logic              fieldIn,
  input  logic              region50,
  input  logic [DATA_W-1:0] cpuOpenBus,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0]  hCap, vCap;
  logic [DATA_W-1:0] busLatch;
  logic [DATA_W-1:0] hByte, vByte, statByte, nextByte;

  assign hByte = st.hiByteH ? {busLatch[DATA_W-1:HI_W], hCap[CNT_W-1:DATA_W]}
                            : hCap[DATA_W-1:0];
  assign vByte = st.hiByteV ? {busLatch[DATA_W-1:HI_W], vCap[CNT_W-1:DATA_W]}
                            : vCap[DATA_W-1:0];
  assign statByte = {fieldIn, st.statBit6, busLatch[5], region50, VERSION};

  always_comb begin
    nextByte = busLatch;
    if (st.readH)         nextByte = hByte;
    else if (st.readV)    nextByte = vByte;
    else if (st.readStat) nextByte = statByte;
    else if (st.readTrig) nextByte = cpuOpenBus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCap     <= '0;
      vCap     <= '0;
      busLatch <= '1;
      rdData   <= '1;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= st.anyRead;
      if (st.anyRead) rdData <= nextByte;
      if (st.capture) begin
        hCap <= hLive;
        vCap <= vLive;
      end
      if (st.readH || st.readV || st.readStat) busLatch <= nextByte;
    end
  end

  a_r10_valid_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    st.anyRead |=> rdValid);
  a_r2_capture_copies: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |=> (hCap == $past(hLive) && vCap == $past(vLive)));
  a_r3_no_capture_holds: assert property (@(posedge clk) disable iff (!rstN)
    !st.capture |=> ($stable(hCap) && $stable(vCap)));
  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(st.readH || st.readV || st.readStat) |=> $stable(busLatch));
  a_r6_high_keeps_upper: assert property (@(posedge clk) disable iff (!rstN)
    (st.readH && st.hiByteH) |=> (rdData[DATA_W-1:HI_W] == $past(busLatch[DATA_W-1:HI_W])));
endmodule

// File: rtl/beam_latch_readout.sv
module beam_latch_readout
  import beam_latch_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int DATA_W  = 8,
  parameter logic [3:0] VERSION = 4'd3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic [1:0]        rdSel,
  input  logic              ioGate,
  input  logic [CNT_W-1:0]  hLive,
  input  logic [CNT_W-1:0]  vLive,
  input  logic              fieldIn,
  input  logic              region50,
  input  logic [DATA_W-1:0] cpuOpenBus,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  strobeT st;

  beam_latch_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdSel(rdSel),
    .ioGate(ioGate), .st(st)
  );

  beam_latch_dpath #(.CNT_W(CNT_W), .DATA_W(DATA_W), .VERSION(VERSION)) dpath_i (
    .clk(clk), .rstN(rstN), .st(st), .hLive(hLive), .vLive(vLive),
    .fieldIn(fieldIn), .region50(region50), .cpuOpenBus(cpuOpenBus),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/beam_latch_readout_tb_top.sv
module beam_latch_readout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] VER = 4'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStrobe = 1'b0;
  logic [1:0] rdSel = 2'd0;
  logic ioGate = 1'b1;
  logic [8:0] hLive = '0, vLive = '0;
  logic fieldIn = 1'b0, region50 = 1'b0;
  logic [7:0] cpuOpenBus = 8'h00;
  logic [7:0] rdData;
  logic rdValid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string tagQ[$];

  // Reference model state
  logic [7:0] mLatch = 8'hFF;
  logic [8:0] mH = '0, mV = '0;
  logic mHT = 1'b0, mVT = 1'b0, mFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beam_latch_readout #(.VERSION(VER)) dut_i (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdSel(rdSel), .ioGate(ioGate),
    .hLive(hLive), .vLive(vLive), .fieldIn(fieldIn), .region50(region50),
    .cpuOpenBus(cpuOpenBus), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Driver: predicts the byte from the model, pushes it, then strobes.
  task automatic doRead(input logic [1:0] sel, input string tag);
    logic [7:0] e;
    @(negedge clk);
    case (sel)
      2'd0: begin
        e = cpuOpenBus;
        if (ioGate) begin mH = hLive; mV = vLive; mFlag = 1'b1; end
      end
      2'd1: begin
        e = mHT ? {mLatch[7:1], mH[8]} : mH[7:0];
        mHT = !mHT; mLatch = e;
      end
      2'd2: begin
        e = mVT ? {mLatch[7:1], mV[8]} : mV[7:0];
        mVT = !mVT; mLatch = e;
      end
      default: begin
        e = {fieldIn, (!ioGate || mFlag), mLatch[5], region50, VER};
        if (ioGate) mFlag = 1'b0;
        mHT = 1'b0; mVT = 1'b0; mLatch = e;
      end
    endcase
    expQ.push_back(e);
    tagQ.push_back(tag);
    rdSel = sel;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(rdData, 8'hxx, "R10 unexpected rdValid");
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData, e, t);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdData, 8'hFF, "R1 reset rdData");
    check({7'd0, rdValid}, 8'h00, "R1 reset rdValid");
    rstN = 1'b1;

    hLive = 9'h1B4; vLive = 9'h0C3; fieldIn = 1'b1; cpuOpenBus = 8'h5A;
    doRead(2'd1, "R1 held h low zero");
    doRead(2'd1, "R1 held h high zero");
    doRead(2'd3, "R4 flag clear after reset, R8 status");
    doRead(2'd0, "R2 trigger returns open bus");
    hLive = 9'h011; vLive = 9'h122;
    doRead(2'd1, "R6 h low byte");
    doRead(2'd1, "R6 h high byte");
    doRead(2'd2, "R6 v low byte independent");
    doRead(2'd2, "R6 v high byte");
    doRead(2'd1, "R6 h low again");
    doRead(2'd3, "R4 flag set read, R7 clears toggles");
    doRead(2'd1, "R7 h low after status");
    doRead(2'd3, "R4 flag cleared by prior status");
    ioGate = 1'b0; cpuOpenBus = 8'hC3;
    doRead(2'd0, "R3 gated trigger open bus");
    doRead(2'd1, "R3 h unchanged low");
    doRead(2'd1, "R3 h unchanged high");
    ioGate = 1'b1;
    doRead(2'd0, "R2 capture second value");
    ioGate = 1'b0; region50 = 1'b1; fieldIn = 1'b0;
    doRead(2'd3, "R5 bit6 forced, R8 region");
    ioGate = 1'b1;
    doRead(2'd3, "R5 flag survived ungated status");
    doRead(2'd3, "R4 flag now clear");
    doRead(2'd2, "R2 v captured low");
    cpuOpenBus = 8'h00;
    doRead(2'd0, "R9 trigger keeps latch");
    doRead(2'd2, "R9 v high uses latch");
    doRead(2'd3, "R8 status bit5 from latch");
    repeat (3) @(negedge clk);
    check({7'd0, rdValid}, 8'h00, "R10 valid drops");
    check(8'(expQ.size()), 8'h00, "R10 all reads answered");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule